// File: doc/BRIEF.md
# Lane-Addressable Vector Register File

This block holds a bank of wide vector registers that a datapath can view at three granularities: the whole 128-bit register, two 64-bit lanes, or four 32-bit lanes. Two read ports work independently, and each one selects a register, a lane width and a lane index. A read returns the selected lane right-aligned and zero-extended to the full output width. A single write port uses the same addressing. A write can update one lane and leave the rest of the register intact, or replace the whole register.

A write port qualifier, `wr_scalar`, marks a scalar write. A scalar write puts the value in the bottom 64 bits, zero-extended from the lane width, and clears the upper 64 bits whatever lane index is supplied. This is how scalar floating-point results, narrow loads and moves from integer registers land in a vector register. An illegal lane index, or the reserved width code, raises an error flag and blocks the write. Reads are combinational. Writes commit on the rising clock edge. Reset clears every register.

There is no back-pressure. Every port is a plain control or data pin: `wr_en` commits in the cycle it is high, and both read ports always answer in the same cycle.

Top module: `vec_lane_regfile`

## Requirements
- R1: An active-low reset clears all 128 bits of every register, so every read after reset returns zero.
- R2: With width code 2'b10 a write replaces all 128 bits and a read returns all 128 bits. The lane index is ignored.
- R3: With width code 2'b00, lane n (n = 0..3) is bits 32n+31:32n. A read returns that lane in bits 31:0 with bits 127:32 zero.
- R4: With width code 2'b01, lane 0 is bits 63:0 and lane 1 is bits 127:64. A read returns that lane in bits 63:0 with bits 127:64 zero.
- R5: The following are illegal: width 2'b11, or width 2'b01 with a lane index of 2 or 3 (the latter only when `wr_scalar` is low for writes). An illegal write raises `wr_err` in the same cycle and changes no register. An illegal read raises its error flag and returns zero data.
- R6: A non-scalar lane write (width 2'b00 or 2'b01) changes only the bits of the addressed lane.
- R7: A scalar write (`wr_scalar`=1, width 2'b00 or 2'b01) writes the low 32 or 64 data bits, zero-extended, into bits 63:0 and clears bits 127:64. The lane index is ignored. With width 2'b10 the scalar flag has no effect.
- R8: A read of the register being written in the same cycle returns the old contents. The new contents are visible in the cycle after the edge.
- R9: The two read ports are independent and may address the same or different registers, widths and lanes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_idx | input | 5 | Read port 0 register number |
| rd0_width | input | 2 | Read port 0 lane width code |
| rd0_lane | input | 2 | Read port 0 lane index |
| rd0_data | output | 128 | Read port 0 lane value, zero-extended |
| rd0_err | output | 1 | Read port 0 illegal lane or width |
| rd1_idx | input | 5 | Read port 1 register number |
| rd1_width | input | 2 | Read port 1 lane width code |
| rd1_lane | input | 2 | Read port 1 lane index |
| rd1_data | output | 128 | Read port 1 lane value, zero-extended |
| rd1_err | output | 1 | Read port 1 illegal lane or width |
| wr_en | input | 1 | Write commit strobe |
| wr_idx | input | 5 | Write register number |
| wr_width | input | 2 | Write lane width code |
| wr_lane | input | 2 | Write lane index |
| wr_scalar | input | 1 | Scalar write: low lane plus clear of bits 127:64 |
| wr_data | input | 128 | Write data, lane value in the low bits |
| wr_err | output | 1 | Write rejected as illegal |

## Verification
The hardest case to reach is a scalar write that lands on a register whose upper half, and whose other 32-bit lanes, already hold non-zero data while the supplied lane index points away from lane 0. The stimulus first fills the target with a full-width pattern. It then issues the scalar write with lane index 3 and reads back every lane through both ports. The same-cycle read-during-write case is produced by driving a read and a write to one register in a single cycle. The old value is expected in that cycle and the new value in the following one.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [1:0] {
    LW32  = 2'b00,
    LW64  = 2'b01,
    LWALL = 2'b10,
    LWRSV = 2'b11
  } lane_w_e;

  localparam int LANES32 = 4;
  localparam int LANES64 = 2;

  function automatic logic lane_legal(input lane_w_e w, input logic [1:0] lane);
    case (w)
      LW32:    lane_legal = 1'b1;
      LW64:    lane_legal = (lane[1] == 1'b0);
      LWALL:   lane_legal = 1'b1;
      default: lane_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vrf_read_port.sv
module vrf_read_port
  import vrf_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] reg_val,
  input  lane_w_e          width,
  input  logic [1:0]       lane,
  output logic [VEC_W-1:0] data,
  output logic             err
);
  localparam int Q_W = VEC_W / LANES32;
  localparam int H_W = VEC_W / LANES64;

  logic [Q_W-1:0] quarter [LANES32];
  logic [H_W-1:0] half    [LANES64];

  for (genvar g = 0; g < LANES32; g++) begin : g_q
    assign quarter[g] = reg_val[g*Q_W +: Q_W];
  end
  for (genvar h = 0; h < LANES64; h++) begin : g_h
    assign half[h] = reg_val[h*H_W +: H_W];
  end

  always_comb begin
    err  = !lane_legal(width, lane);
    data = '0;
    if (!err) begin
      case (width)
        LW32:    data[Q_W-1:0] = quarter[lane];
        LW64:    data[H_W-1:0] = half[lane[0]];
        default: data = reg_val;
      endcase
    end
  end

  always_comb begin
    if (width == LW32) begin
      AST_RD_NARROW_ZEXT: assert (data[VEC_W-1:Q_W] == '0); // R3
    end
    if (err) begin
      AST_RD_ERR_ZERO: assert (data == '0); // R5
    end
  end
endmodule

// File: rtl/vrf_write_merge.sv
module vrf_write_merge
  import vrf_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] old_val,
  input  lane_w_e          width,
  input  logic [1:0]       lane,
  input  logic             scalar,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] new_val,
  output logic             err
);
  localparam int Q_W = VEC_W / LANES32;
  localparam int H_W = VEC_W / LANES64;

  logic [LANES32-1:0] hit;
  logic [VEC_W-1:0]   merged;
  logic [VEC_W-1:0]   scalar_val;
  logic [VEC_W-1:0]   keep_mask;

  for (genvar g = 0; g < LANES32; g++) begin : g_lane
    logic [Q_W-1:0] src;
    assign hit[g] = ((width == LW32) && (lane == 2'(g))) ||
                    ((width == LW64) && (lane[0] == 1'(g / 2)));
    assign src = (width == LW32) ? wdata[Q_W-1:0] : wdata[(g % 2)*Q_W +: Q_W];
    assign merged[g*Q_W +: Q_W]    = hit[g] ? src : old_val[g*Q_W +: Q_W];
    assign keep_mask[g*Q_W +: Q_W] = hit[g] ? '0 : '1;
  end

  always_comb begin
    scalar_val = '0;
    if (width == LW32) scalar_val[Q_W-1:0] = wdata[Q_W-1:0];
    else               scalar_val[H_W-1:0] = wdata[H_W-1:0];
  end

  always_comb begin
    err = (width == LWRSV) || (!scalar && !lane_legal(width, lane));
    if (err)                  new_val = old_val;
    else if (width == LWALL)  new_val = wdata;
    else if (scalar)          new_val = scalar_val;
    else                      new_val = merged;
  end

  always_comb begin
    if (!scalar && !err && (width != LWALL)) begin
      AST_LANE_WRITE_LOCAL: assert (((new_val ^ old_val) & keep_mask) == '0); // R6
    end
  end
endmodule

// File: rtl/vec_lane_regfile.sv
module vec_lane_regfile
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int VEC_W    = 128,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [1:0]       rd0_width,
  input  logic [1:0]       rd0_lane,
  output logic [VEC_W-1:0] rd0_data,
  output logic             rd0_err,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [1:0]       rd1_width,
  input  logic [1:0]       rd1_lane,
  output logic [VEC_W-1:0] rd1_data,
  output logic             rd1_err,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_width,
  input  logic [1:0]       wr_lane,
  input  logic             wr_scalar,
  input  logic [VEC_W-1:0] wr_data,
  output logic             wr_err
);
  localparam int NRP = 2;
  localparam int H_W = VEC_W / 2;

  logic [VEC_W-1:0] bank [NUM_REGS];
  logic [VEC_W-1:0] wr_next;

  logic [IDX_W-1:0] rp_idx   [NRP];
  logic [1:0]       rp_width [NRP];
  logic [1:0]       rp_lane  [NRP];
  logic [VEC_W-1:0] rp_data  [NRP];
  logic             rp_err   [NRP];

  assign rp_idx[0]   = rd0_idx;
  assign rp_width[0] = rd0_width;
  assign rp_lane[0]  = rd0_lane;
  assign rp_idx[1]   = rd1_idx;
  assign rp_width[1] = rd1_width;
  assign rp_lane[1]  = rd1_lane;

  for (genvar p = 0; p < NRP; p++) begin : g_rp
    vrf_read_port #(.VEC_W(VEC_W)) u_rp (
      .reg_val (bank[rp_idx[p]]),
      .width   (lane_w_e'(rp_width[p])),
      .lane    (rp_lane[p]),
      .data    (rp_data[p]),
      .err     (rp_err[p])
    );
  end

  assign rd0_data = rp_data[0];
  assign rd0_err  = rp_err[0];
  assign rd1_data = rp_data[1];
  assign rd1_err  = rp_err[1];

  vrf_write_merge #(.VEC_W(VEC_W)) u_wm (
    .old_val (bank[wr_idx]),
    .width   (lane_w_e'(wr_width)),
    .lane    (wr_lane),
    .scalar  (wr_scalar),
    .wdata   (wr_data),
    .new_val (wr_next),
    .err     (wr_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) bank[r] <= '0;
    end else if (wr_en && !wr_err) begin
      bank[wr_idx] <= wr_next;
    end
  end

  AST_SCALAR_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_scalar && (wr_width == LW32 || wr_width == LW64))
      |=> (bank[$past(wr_idx)][VEC_W-1:H_W] == '0)); // R7

  AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_err) |=> (bank[$past(wr_idx)] == $past(bank[wr_idx]))); // R5

  AST_FULL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_width == LWALL) |=> (bank[$past(wr_idx)] == $past(wr_data))); // R2

  AST_LANE0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_scalar && wr_width == LW32 && wr_lane != 2'd0)
      |=> (bank[$past(wr_idx)][VEC_W/4-1:0] == $past(bank[wr_idx][VEC_W/4-1:0]))); // R6
endmodule

// File: tb/sim_vec_lane_regfile.sv
`timescale 1ns/1ps
module sim_vec_lane_regfile;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [1:0]   rd0_width = '0, rd1_width = '0, wr_width = '0;
  logic [1:0]   rd0_lane = '0, rd1_lane = '0, wr_lane = '0;
  logic [127:0] rd0_data, rd1_data, wr_data = '0;
  logic         rd0_err, rd1_err, wr_err;
  logic         wr_en = 1'b0, wr_scalar = 1'b0;

  always #2.5 clk = ~clk;

  vec_lane_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_width(rd0_width), .rd0_lane(rd0_lane),
    .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_idx(rd1_idx), .rd1_width(rd1_width), .rd1_lane(rd1_lane),
    .rd1_data(rd1_data), .rd1_err(rd1_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width), .wr_lane(wr_lane),
    .wr_scalar(wr_scalar), .wr_data(wr_data), .wr_err(wr_err)
  );

  typedef struct {
    int           port;
    logic [127:0] d;
    logic         e;
    string        tag;
  } exp_t;

  exp_t         sb [$];
  logic [127:0] model [32];
  int           n_checks = 0;
  int           n_fail = 0;
  bit           pend = 0;
  logic [4:0]   pend_idx;
  logic [127:0] pend_val;
  bit           finished = 0;

  // expected read from the requirements (R3, R4, R2, R5)
  function automatic void model_read(input logic [127:0] v, input logic [1:0] w,
                                     input logic [1:0] l, output logic [127:0] d,
                                     output logic e);
    d = '0; e = 1'b0;
    case (w)
      2'b00: d[31:0] = v[32*l +: 32];
      2'b01: if (l > 1) e = 1'b1; else d[63:0] = v[64*l +: 64];
      2'b10: d = v;
      default: e = 1'b1;
    endcase
  endfunction

  // expected write outcome (R2, R5, R6, R7)
  function automatic logic [127:0] model_write(input logic [127:0] v, input logic [1:0] w,
      input logic [1:0] l, input logic s, input logic [127:0] wd, output logic e);
    logic [127:0] r;
    r = v;
    e = (w == 2'b11) || (!s && w == 2'b01 && l > 1);
    if (!e) begin
      if (w == 2'b10) r = wd;
      else if (s) r = (w == 2'b00) ? {96'd0, wd[31:0]} : {64'd0, wd[63:0]};
      else if (w == 2'b00) r[32*l +: 32] = wd[31:0];
      else r[64*l +: 64] = wd[63:0];
    end
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    if (pend) begin model[pend_idx] = pend_val; pend = 0; end
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int p, input int idx, input logic [1:0] w,
                    input logic [1:0] l, input string tag);
    exp_t x;
    if (p == 0) begin rd0_idx = 5'(idx); rd0_width = w; rd0_lane = l; end
    else        begin rd1_idx = 5'(idx); rd1_width = w; rd1_lane = l; end
    x.port = p; x.tag = tag;
    model_read(model[idx], w, l, x.d, x.e);
    sb.push_back(x);
  endtask

  task automatic wr(input int idx, input logic [1:0] w, input logic [1:0] l,
                    input logic s, input logic [127:0] wd, input string tag);
    exp_t x;
    logic e;
    wr_en = 1'b1; wr_idx = 5'(idx); wr_width = w; wr_lane = l; wr_scalar = s; wr_data = wd;
    pend_val = model_write(model[idx], w, l, s, wd, e);
    pend_idx = 5'(idx);
    pend = !e;
    x.port = 2; x.d = '0; x.e = e; x.tag = tag;
    sb.push_back(x);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t x;
      logic [127:0] ad;
      logic ae;
      x = sb.pop_front();
      case (x.port)
        0: begin ad = rd0_data; ae = rd0_err; end
        1: begin ad = rd1_data; ae = rd1_err; end
        default: begin ad = '0; ae = wr_err; end
      endcase
      n_checks++;
      if (ad !== x.d || ae !== x.e) begin
        n_fail++;
        $display("FAIL %s port%0d: actual data=%h err=%b expected data=%h err=%b",
                 x.tag, x.port, ad, ae, x.d, x.e);
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // put data in, then reset again to see it cleared (R1)
    step(); wr(5, 2'b10, 0, 0, {4{32'hDEADBEEF}}, "R2 pre");
    step(); wr(9, 2'b10, 0, 0, {4{32'h12345678}}, "R2 pre");
    step();
    @(negedge clk); #1 rst_n = 1'b0;
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int r = 0; r < 32; r += 2) begin
      step(); rd(0, r, 2'b10, 0, "R1 reset"); rd(1, r + 1, 2'b10, 0, "R1 reset");
    end
    // full width (R2), two ports independent (R9)
    step(); wr(3, 2'b10, 2'b11, 0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, "R2 full");
    step(); rd(0, 3, 2'b10, 0, "R2 full read"); rd(1, 3, 2'b00, 2, "R9 second port");
    // 32-bit lanes (R3, R6)
    step(); wr(7, 2'b10, 0, 0, {4{32'hA5A5A5A5}}, "R2 fill");
    for (int l = 0; l < 4; l++) begin
      step(); wr(7, 2'b00, 2'(l), 0, {96'hF, 32'h1000_0000 + 32'(l)}, "R6 lane32 write");
      rd(0, 7, 2'b10, 0, "R6 before");
      step(); rd(0, 7, 2'b10, 0, "R6 after lane32"); rd(1, 7, 2'b00, 2'(l), "R3 lane32 read");
    end
    // 64-bit lanes (R4, R6)
    step(); wr(10, 2'b10, 0, 0, {4{32'h5A5A5A5A}}, "R2 fill");
    step(); wr(10, 2'b01, 1, 0, 128'hFFFF_0000_1111_2222_CAFE_F00D_BEEF_0001, "R6 lane64 write");
    step(); rd(0, 10, 2'b01, 0, "R4 lane64 lo"); rd(1, 10, 2'b01, 1, "R4 lane64 hi");
    // illegal accesses (R5)
    step(); wr(10, 2'b01, 2, 0, '1, "R5 bad lane write");
    step(); wr(10, 2'b11, 0, 0, '1, "R5 reserved write");
    step(); rd(0, 10, 2'b10, 0, "R5 unchanged"); rd(1, 10, 2'b01, 3, "R5 bad lane read");
    step(); rd(0, 10, 2'b11, 0, "R5 reserved read");
    // scalar writes with lane index pointing away (R7)
    step(); wr(7, 2'b10, 0, 0, '1, "R2 fill");
    step(); wr(7, 2'b00, 3, 1, {64'hABCD, 64'h9999_8888_7777_6666}, "R7 scalar32");
    for (int l = 0; l < 4; l++) begin
      step(); rd(0, 7, 2'b00, 2'(l), "R7 scalar32 lanes"); rd(1, 7, 2'b10, 0, "R7 scalar32 full");
    end
    step(); wr(8, 2'b10, 0, 0, '1, "R2 fill");
    step(); wr(8, 2'b01, 3, 1, {64'h1, 64'h0123_4567_89AB_CDEF}, "R7 scalar64 lane ignored");
    step(); rd(0, 8, 2'b10, 0, "R7 scalar64 full"); rd(1, 8, 2'b01, 1, "R7 scalar64 hi");
    step(); wr(8, 2'b10, 1, 1, {4{32'h7777_1111}}, "R7 scalar full");
    step(); rd(0, 8, 2'b10, 0, "R7 scalar full read");
    // read during write (R8)
    step(); wr(12, 2'b10, 0, 0, {4{32'hC0FFEE00}}, "R8 write");
    rd(0, 12, 2'b10, 0, "R8 old value"); rd(1, 12, 2'b00, 1, "R8 old lane");
    step(); rd(0, 12, 2'b10, 0, "R8 new value"); rd(1, 12, 2'b00, 1, "R8 new lane");
    // mixed traffic (R3 R4 R5 R6 R7 R9)
    seed = 32'h1F2E3D4C;
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      step();
      wr(int'(seed[31:27]), seed[26:25], seed[24:23], seed[22],
         {seed, ~seed, seed ^ 32'h5555AAAA, seed + 32'd7}, "R6 R7 mixed write");
      rd(0, int'(seed[21:17]), seed[16:15], seed[14:13], "R3 R4 mixed rd0");
      rd(1, int'(seed[12:8]), seed[7:6], seed[5:4], "R9 mixed rd1");
    end
    step(); step();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule